// File: doc/BRIEF.md
# Accumulator Rounding Unit with Selectable Half-Case Handling

This block holds a 40-bit multiply-accumulate result and rounds it, on request, toward its upper 16-bit word. The value is split into three fields: an 8-bit overflow field at bits 39:32, an upper word at bits 31:16 and a lower word at bits 15:0. A round adds one to the combined 24-bit overflow-and-upper part when the lower word calls for it. The lower word itself is left as it was. The full 40-bit value is treated as two's complement, so the increment carries out of the upper word into the overflow field and wraps at the top.

A single mode flag decides what happens in the exact halfway case, when the lower word equals 0x8000. In unbiased (convergent) mode the upper word goes up only if it is odd, which leaves an even result. In biased mode the halfway case always rounds up. Every other lower-word value gives the same result in both modes. The flag is taken from bit 12 of a 16-bit control word whenever that word is written. A load port writes a whole 40-bit value into the accumulator, and the rounded result is registered and marked by a one-cycle valid pulse.

Top module: `acc_round_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator is cleared to 0, `round_valid` is 0 and the mode becomes unbiased.
- R2: A clock edge with `cfg_we` high copies `cfg_data[12]` into the mode flag: 0 selects unbiased, 1 selects biased. The other 15 bits of `cfg_data` have no effect on the mode or on the accumulator.
- R3: When the lower word (bits 15:0) is below 0x8000, a round leaves bits 39:16 unchanged in both modes.
- R4: When the lower word is above 0x8000, a round adds 1 to bits 39:16 in both modes.
- R5: In biased mode, a lower word equal to 0x8000 makes a round add 1 to bits 39:16.
- R6: In unbiased mode, a lower word equal to 0x8000 makes a round add 1 to bits 39:16 only when bit 16 is 1. When bit 16 is 0, bits 39:16 stay unchanged.
- R7: A round never changes bits 15:0.
- R8: The increment carries from the upper word into the overflow field, and bits 39:16 wrap modulo 2^24 (0xFFFFFF becomes 0x000000).
- R9: A round requested at one clock edge shows its result on `acc_q` right after that edge, with `round_valid` high for that one cycle. A round held for consecutive edges rounds again at each of them.
- R10: A clock edge with `load_en` high writes `load_val` into the accumulator and raises no valid pulse. If `load_en` and `round_req` are both high at the same edge, the load wins and no round takes place.
- R11: With neither `load_en` nor `round_req` high at an edge, `acc_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_val` into the accumulator |
| load_val | input | 40 | Value to load |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_data | input | 16 | Control word; bit 12 is the mode flag |
| round_req | input | 1 | Round strobe |
| acc_q | output | 40 | Current accumulator, showing the rounded value after a round |
| round_valid | output | 1 | One-cycle pulse marking a completed round |

## Verification
Each result is due one edge after its cause. A round, a load or a control write sampled at one edge is visible just after that edge, and the bench reads it at the following falling edge. The scoreboard driver queues the expected value at the rising edge that samples a round. The monitor then requires `round_valid` and the matching `acc_q` at the very next falling edge, so an early, late, missing or extra pulse is reported. Loads, mode writes, collisions and hold periods are checked at that same falling-edge point, against a bench model that tracks the accumulator and the mode.

// File: rtl/acc_rnd_pkg.sv
package acc_rnd_pkg;

    localparam int OVF_W    = 8;
    localparam int WORD_W   = 16;
    localparam int CFG_W    = 16;
    localparam int MODE_BIT = 12;

    localparam int UPPER_W  = OVF_W + WORD_W;
    localparam int ACC_W    = UPPER_W + WORD_W;

    localparam logic [WORD_W-1:0] HALF_LSB = WORD_W'(1) << (WORD_W - 1);

    typedef struct packed {
        logic [OVF_W-1:0]  ovf;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_t;

    typedef enum logic {
        RND_EVEN = 1'b0,
        RND_UP   = 1'b1
    } rnd_mode_e;

    typedef enum logic [1:0] {
        LO_BELOW = 2'd0,
        LO_HALF  = 2'd1,
        LO_ABOVE = 2'd2
    } lo_class_e;

    function automatic lo_class_e classify_lo(input logic [WORD_W-1:0] lo);
        if (lo == HALF_LSB)
            return LO_HALF;
        else if (lo[WORD_W-1])
            return LO_ABOVE;
        else
            return LO_BELOW;
    endfunction

    function automatic logic [UPPER_W-1:0] upper_of(input acc_t a);
        return {a.ovf, a.hi};
    endfunction

endpackage

// File: rtl/acc_rnd_mode.sv
module acc_rnd_mode
    import acc_rnd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    output rnd_mode_e        mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= RND_EVEN;
        else if (cfg_we)
            mode_q <= rnd_mode_e'(cfg_data[MODE_BIT]);
    end

    // R1: mode starts unbiased after reset
    a_r1_mode_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mode_q == RND_EVEN));

    // R2: mode only changes on a control write
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(mode_q));

endmodule

// File: rtl/acc_rnd_step.sv
module acc_rnd_step
    import acc_rnd_pkg::*;
(
    input  acc_t               cur,
    input  rnd_mode_e          mode,
    output logic               bump,
    output logic [UPPER_W-1:0] upper_next
);

    lo_class_e          lo_cls;
    logic [UPPER_W-1:0] upper_cur;

    always_comb begin
        lo_cls    = classify_lo(cur.lo);
        upper_cur = upper_of(cur);
        unique case (lo_cls)
            LO_ABOVE: bump = 1'b1;
            LO_HALF:  bump = (mode == RND_UP) ? 1'b1 : cur.hi[0];
            default:  bump = 1'b0;
        endcase
        upper_next = upper_cur + UPPER_W'(bump);
    end

endmodule

// File: rtl/acc_round_unit.sv
module acc_round_unit
    import acc_rnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ACC_W-1:0]  load_val,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              round_req,
    output logic [ACC_W-1:0]  acc_q,
    output logic              round_valid
);

    acc_t               acc_r;
    rnd_mode_e          mode_q;
    logic               bump;
    logic [UPPER_W-1:0] upper_next;
    logic [UPPER_W-1:0] upper_q;

    acc_rnd_mode u_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_data (cfg_data),
        .mode_q   (mode_q)
    );

    acc_rnd_step u_step (
        .cur        (acc_r),
        .mode       (mode_q),
        .bump       (bump),
        .upper_next (upper_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r       <= '0;
            round_valid <= 1'b0;
        end else begin
            round_valid <= round_req & ~load_en;
            if (load_en)
                acc_r <= acc_t'(load_val);
            else if (round_req)
                acc_r <= acc_t'({upper_next, acc_r.lo});
        end
    end

    assign acc_q   = acc_r;
    assign upper_q = upper_of(acc_r);

    // R9: a valid pulse always has a round request behind it
    a_r9_valid_cause: assert property (@(posedge clk) disable iff (rst)
        round_valid |-> ($past(round_req) && !$past(load_en)));

    // R7: lower word untouched by rounding
    a_r7_low_kept: assert property (@(posedge clk) disable iff (rst)
        round_valid |-> (acc_r.lo == $past(acc_r.lo)));

    // R3: below half leaves upper part alone
    a_r3_below_half: assert property (@(posedge clk) disable iff (rst)
        (round_valid && ($past(acc_r.lo) < HALF_LSB)) |-> (upper_q == $past(upper_q)));

    // R4: above half increments
    a_r4_above_half: assert property (@(posedge clk) disable iff (rst)
        (round_valid && ($past(acc_r.lo) > HALF_LSB)) |->
            (upper_q == UPPER_W'($past(upper_q) + 1'b1)));

    // R5: biased half case always increments
    a_r5_biased_half: assert property (@(posedge clk) disable iff (rst)
        (round_valid && ($past(acc_r.lo) == HALF_LSB) && ($past(mode_q) == RND_UP)) |->
            (upper_q == UPPER_W'($past(upper_q) + 1'b1)));

    // R6: unbiased half case lands on an even upper word
    a_r6_even_result: assert property (@(posedge clk) disable iff (rst)
        (round_valid && ($past(acc_r.lo) == HALF_LSB) && ($past(mode_q) == RND_EVEN)) |->
            (acc_r.hi[0] == 1'b0));

    // R10: load writes the whole value and gives no pulse
    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        $past(load_en) |-> ((acc_q == $past(load_val)) && !round_valid));

    // R11: idle edges keep the value
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(load_en) && !$past(round_req)) |-> $stable(acc_q));

endmodule

// File: tb/acc_round_unit_tb.sv
module acc_round_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_en;
    logic [39:0] load_val;
    logic        cfg_we;
    logic [15:0] cfg_data;
    logic        round_req;
    logic [39:0] acc_q;
    logic        round_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [39:0] model_acc;
    logic        model_biased;
    logic [39:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    acc_round_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .load_en     (load_en),
        .load_val    (load_val),
        .cfg_we      (cfg_we),
        .cfg_data    (cfg_data),
        .round_req   (round_req),
        .acc_q       (acc_q),
        .round_valid (round_valid)
    );

    function automatic logic [39:0] ref_round(input logic [39:0] v, input logic biased);
        logic [23:0] up;
        logic [15:0] lo;
        logic        add;
        up  = v[39:16];
        lo  = v[15:0];
        if (lo > 16'h8000)      add = 1'b1;
        else if (lo < 16'h8000) add = 1'b0;
        else                    add = biased | up[0];
        return {up + {23'd0, add}, lo};
    endfunction

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: compares queued round results one falling edge after the sampling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (exp_q.size() > 0) begin
                logic [39:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " valid"}, {39'd0, round_valid}, 40'd1);
                check(t, acc_q, e);
            end else if (round_valid) begin
                check("R9 unexpected valid", {39'd0, round_valid}, 40'd0);
            end
        end
    end

    task automatic do_load(input logic [39:0] v);
        load_en  = 1'b1;
        load_val = v;
        @(posedge clk);
        @(negedge clk);
        load_en   = 1'b0;
        model_acc = v;
    endtask

    task automatic do_cfg(input logic [15:0] d);
        cfg_we   = 1'b1;
        cfg_data = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we       = 1'b0;
        model_biased = d[12];
    endtask

    task automatic do_round(input string tag, input int n);
        round_req = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_acc = ref_round(model_acc, model_biased);
            exp_q.push_back(model_acc);
            tag_q.push_back(tag);
            @(negedge clk);
        end
        round_req = 1'b0;
    endtask

    task automatic load_round(input string tag, input logic [39:0] v, input logic [39:0] exp);
        do_load(v);
        do_round(tag, 1);
        check({tag, " fixed"}, acc_q, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_val = '0; cfg_we = 1'b0;
        cfg_data = '0; round_req = 1'b0; model_acc = '0; model_biased = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset acc", acc_q, 40'd0);
        check("R1 reset valid", {39'd0, round_valid}, 40'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 default unbiased, R6 even upper stays
        load_round("R1 R6 default unbiased", 40'h00_0000_8000, 40'h00_0000_8000);
        load_round("R6 odd upper", 40'h00_0001_8000, 40'h00_0002_8000);

        // R2 biased via bit 12
        do_cfg(16'h1000);
        check("R2 cfg leaves acc", acc_q, 40'h00_0002_8000);
        load_round("R5 biased half", 40'h00_0000_8000, 40'h00_0001_8000);
        load_round("R5 biased odd", 40'h00_0001_8000, 40'h00_0002_8000);
        load_round("R4 above biased", 40'h00_0002_8001, 40'h00_0003_8001);
        load_round("R3 below biased", 40'h00_0001_7FFF, 40'h00_0001_7FFF);

        // R2 other bits ignored
        do_cfg(16'hEFFF);
        load_round("R2 R6 other bits ignored", 40'h00_0002_8000, 40'h00_0002_8000);
        load_round("R4 above unbiased", 40'h00_0000_8001, 40'h00_0001_8001);
        load_round("R3 below unbiased", 40'h00_0002_7FFF, 40'h00_0002_7FFF);
        load_round("R7 low kept", 40'h12_3456_0000, 40'h12_3456_0000);

        // R8 carries and wrap
        load_round("R8 carry into ovf", 40'h00_FFFF_8001, 40'h01_0000_8001);
        load_round("R8 wrap", 40'hFF_FFFF_C000, 40'h00_0000_C000);
        load_round("R8 R6 wrap odd half", 40'hFF_FFFF_8000, 40'h00_0000_8000);
        load_round("R6 negative even", 40'hFF_8000_8000, 40'hFF_8000_8000);

        // R9 back-to-back rounds in biased mode
        do_cfg(16'h1000);
        do_load(40'h00_0000_8000);
        do_round("R9 back to back", 3);
        check("R9 after burst", acc_q, 40'h00_0003_8000);

        // R11 hold
        repeat (4) @(negedge clk);
        check("R11 hold", acc_q, 40'h00_0003_8000);

        // R10 load wins over round
        load_en = 1'b1; load_val = 40'h00_0005_9000; round_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_en = 1'b0; round_req = 1'b0; model_acc = 40'h00_0005_9000;
        check("R10 load wins", acc_q, 40'h00_0005_9000);
        check("R10 no valid", {39'd0, round_valid}, 40'd0);

        // mixed patterns against the model
        for (int i = 0; i < 60; i++) begin
            logic [39:0] v;
            v = {$urandom(), $urandom()};
            case (i % 4)
                0: v[15:0] = 16'h8000;
                1: v[15:0] = 16'h8000 + 16'($urandom_range(0, 2)) - 16'd1;
                default: ;
            endcase
            if (i % 7 == 0) do_cfg(16'($urandom()));
            do_load(v);
            do_round("R3 R4 R5 R6 R8 pattern", 1 + (i % 2));
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule